// File: doc/BRIEF.md
# Channel-List Sampling Controller

This block sequences 12-bit conversions for a 16-input sampling front end. Software fills a small channel list through a 16-bit register bus. Each list entry names an input, a gain code, a unipolar flag and a differential flag. A trigger launches one conversion of the entry at the list head and then moves the head on. After the last loaded entry the head returns to the first one. The trigger comes from a bus read, a scan tick or an external pulse, depending on the selected mode.

Each conversion is handed to an abstract converter over a request/done handshake. The returned code is stored in a sample FIFO, and software pops the FIFO through the bus. Status bits report the fill levels. Three interrupt sources latch pending flags, which drive a single interrupt line through a global enable.

Register map (byte offsets on `bus_addr`):
- 0x00: writing sets control word A; reading starts a conversion and returns 0.
- 0x02: writing sets control word B.
- 0x04: reading returns status; any write clears the pending flags.
- 0x06: writing appends a list entry; reading pops a sample.

Top module: `adcq_ctrl`

## Requirements
- R1: Control word A bits [1:0] select the trigger mode: 0 is off, 1 is bus read of offset 0x00, 2 is `scan_tick`, 3 is `ext_trig`. The state after reset is off. In off mode no trigger starts a conversion, and a read of offset 0x00 has no effect.
- R2: A list entry uses these bits: [3:0] input, [5:4] gain, [6] unipolar, [7] differential. From the start of a conversion until `conv_done`, `conv_req` stays high and `conv_cfg` carries the head entry unchanged.
- R3: Each accepted trigger converts the entry at the list head, then advances the head. After the last loaded entry the head wraps to the first.
- R4: The channel list holds 16 entries. A write to a full list is dropped. Status bit 1 is set while the list is full.
- R5: The sample FIFO holds 64 codes. A code arriving while the FIFO is full is dropped. Status bits: 2 is empty, 3 is half-full (at least 32 codes), 4 is full. After reset the status reads 0x0004.
- R6: Control word B bit 9 enables the channel list and bit 10 enables the sample FIFO. A cleared bit empties its FIFO. List writes while bit 9 is clear are dropped.
- R7: A read of offset 0x06 returns the oldest code in bits [11:0] with bits [15:12] zero, and removes that code. When the FIFO is empty the read returns 0.
- R8: Control word A enable bits are: 8 for half-full, 9 for external, 10 for list-wrap. Pending flags appear at status bits 8 (FIFO reached half-full), 9 (`ext_trig` seen) and 10 (the conversion of the last list entry finished). `irq` is high exactly when bit 15 is set and some flag is pending.
- R9: Any write to offset 0x04 clears all pending flags. A source event in the same cycle as the clear still leaves its flag set.
- R10: A trigger is ignored while a conversion is in progress, while the list is empty, or while the list is disabled.
- R11: In mode 2 only `scan_tick` starts conversions, and in mode 3 only `ext_trig` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| conv_req | output | 1 | Conversion in progress |
| conv_cfg | output | 8 | Entry being converted |
| conv_done | input | 1 | Converter result strobe |
| conv_code | input | 12 | Converter result |
| scan_tick | input | 1 | Scan trigger pulse |
| ext_trig | input | 1 | External trigger and interrupt source |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can occur on the same clock edge.

The first is a write to the clear address landing on the edge where `ext_trig` is high. The bench drives both on the same edge. It then checks that the external pending flag is still set, and that a later clear on its own removes it.

The second is a start request arriving while a conversion is still open. The bench issues two start reads back to back. It expects exactly one sample, and expects the list head to have moved by exactly one entry.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int CODE_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRLA = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRLB = 5'h02;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h04;
    localparam logic [ADDR_W-1:0] A_QUEUE = 5'h06;

    localparam int CA_IE     = 15;
    localparam int CA_EN_HF  = 8;
    localparam int CA_EN_EXT = 9;
    localparam int CA_EN_LR  = 10;
    localparam int CB_SF_EN  = 10;
    localparam int CB_CL_EN  = 9;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_BUS  = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_EXT  = 2'd3
    } trig_mode_e;

    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] chan;
    } list_entry_t;

    // pending flag vector: [0] half-full, [1] external, [2] list wrap
    typedef logic [2:0] pend_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input pend_t pend, input logic sf_full, input logic sf_half,
        input logic sf_empty, input logic cl_full, input logic busy);
        logic [DATA_W-1:0] s;
        s = '0;
        s[10:8] = pend;
        s[4]    = sf_full;
        s[3]    = sf_half;
        s[2]    = sf_empty;
        s[1]    = cl_full;
        s[0]    = busy;
        return s;
    endfunction
endpackage

// File: rtl/adcq_chanlist.sv
module adcq_chanlist
    import adcq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  list_entry_t                wr_entry,
    input  logic                       advance,
    output list_entry_t                head_entry,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       at_last
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    list_entry_t    mem [DEPTH];
    logic [CW-1:0]  cnt_q;
    logic [PW-1:0]  head_q;

    assign full       = (cnt_q == CW'(DEPTH));
    assign empty      = (cnt_q == '0);
    assign at_last    = !empty && ((CW'(head_q) + CW'(1)) == cnt_q);
    assign head_entry = mem[head_q];
    assign count      = cnt_q;

    always_ff @(posedge clk) begin
        if (wr_en && !full && !flush)
            mem[cnt_q[PW-1:0]] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q  <= '0;
            head_q <= '0;
        end else begin
            if (wr_en && !full)
                cnt_q <= cnt_q + CW'(1);
            if (advance && !empty)
                head_q <= at_last ? '0 : head_q + PW'(1);
        end
    end
endmodule

// File: rtl/adcq_sample_fifo.sv
module adcq_sample_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= step(wp_q);
            if (pop_ok)  rp_q <= step(rp_q);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
    import adcq_pkg::*;
#(
    parameter int LIST_DEPTH   = 16,
    parameter int SAMPLE_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_req,
    output logic [7:0]        conv_cfg,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    input  logic              scan_tick,
    input  logic              ext_trig,
    output logic              irq
);
    localparam int LCW = $clog2(LIST_DEPTH + 1);
    localparam int SCW = $clog2(SAMPLE_DEPTH + 1);

    logic [DATA_W-1:0] ctrla_q, ctrlb_q, rdata_q;
    logic              busy_q, hf_q;
    list_entry_t       cfg_q;
    pend_t             pend_q, pend_set;

    trig_mode_e        mode;
    logic              list_en, sf_en, trig, start, done, clr_wr;
    logic              hf_now, hf_rise;

    list_entry_t       head_entry;
    logic [LCW-1:0]    list_cnt;
    logic              cl_full, cl_empty, cl_last;
    logic [CODE_W-1:0] sf_dout;
    logic [SCW-1:0]    sf_cnt;
    logic              sf_empty, sf_full;

    assign mode    = trig_mode_e'(ctrla_q[1:0]);
    assign list_en = ctrlb_q[CB_CL_EN];
    assign sf_en   = ctrlb_q[CB_SF_EN];

    always_comb begin
        unique case (mode)
            MODE_BUS:  trig = bus_rd && (bus_addr == A_CTRLA);
            MODE_SCAN: trig = scan_tick;
            MODE_EXT:  trig = ext_trig;
            default:   trig = 1'b0;
        endcase
    end

    assign start   = trig && !busy_q && list_en && !cl_empty;
    assign done    = busy_q && conv_done;
    assign clr_wr  = bus_wr && (bus_addr == A_STAT);
    assign hf_now  = (sf_cnt >= SCW'(SAMPLE_DEPTH / 2));
    assign hf_rise = hf_now && !hf_q;

    assign pend_set[0] = ctrla_q[CA_EN_HF]  && hf_rise;
    assign pend_set[1] = ctrla_q[CA_EN_EXT] && ext_trig;
    assign pend_set[2] = ctrla_q[CA_EN_LR]  && done && cl_last;

    adcq_chanlist #(.DEPTH(LIST_DEPTH)) u_list (
        .clk        (clk),
        .rst        (rst),
        .flush      (!list_en),
        .wr_en      (bus_wr && (bus_addr == A_QUEUE) && list_en),
        .wr_entry   (list_entry_t'(bus_wdata[7:0])),
        .advance    (done),
        .head_entry (head_entry),
        .count      (list_cnt),
        .full       (cl_full),
        .empty      (cl_empty),
        .at_last    (cl_last)
    );

    adcq_sample_fifo #(.DEPTH(SAMPLE_DEPTH), .W(CODE_W)) u_samples (
        .clk   (clk),
        .rst   (rst),
        .flush (!sf_en),
        .push  (done && sf_en),
        .din   (conv_code),
        .pop   (bus_rd && (bus_addr == A_QUEUE)),
        .dout  (sf_dout),
        .count (sf_cnt),
        .empty (sf_empty),
        .full  (sf_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrla_q <= '0;
            ctrlb_q <= '0;
            busy_q  <= 1'b0;
            cfg_q   <= '0;
            pend_q  <= '0;
            hf_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_CTRLA) ctrla_q <= bus_wdata;
            if (bus_wr && bus_addr == A_CTRLB) ctrlb_q <= bus_wdata;
            if (start) begin
                busy_q <= 1'b1;
                cfg_q  <= head_entry;
            end else if (done) begin
                busy_q <= 1'b0;
            end
            hf_q   <= hf_now;
            pend_q <= (clr_wr ? '0 : pend_q) | pend_set;
            if (bus_rd) begin
                unique case (bus_addr)
                    A_STAT:  rdata_q <= pack_status(pend_q, sf_full, hf_now,
                                                    sf_empty, cl_full, busy_q);
                    A_QUEUE: rdata_q <= sf_empty ? '0 :
                                        {{(DATA_W-CODE_W){1'b0}}, sf_dout};
                    default: rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign conv_req  = busy_q;
    assign conv_cfg  = cfg_q;
    assign irq       = ctrla_q[CA_IE] && (pend_q != '0);
endmodule

// File: rtl/adcq_checker.sv
module adcq_checker
    import adcq_pkg::*;
#(
    parameter int LIST_DEPTH   = 16,
    parameter int SAMPLE_DEPTH = 64
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              conv_req,
    input logic                              conv_done,
    input logic [7:0]                        conv_cfg,
    input logic                              irq,
    input logic [DATA_W-1:0]                 ctrla_q,
    input logic                              bus_wr,
    input logic [ADDR_W-1:0]                 bus_addr,
    input logic                              ext_trig,
    input logic                              hf_rise,
    input pend_t                             pend_q,
    input logic [$clog2(LIST_DEPTH+1)-1:0]   list_cnt,
    input logic [$clog2(SAMPLE_DEPTH+1)-1:0] sf_cnt
);
    // R2: request and entry held until the converter answers
    a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
        conv_req && !conv_done |=> conv_req && $stable(conv_cfg));

    // R1: off mode never opens a conversion
    a_r1_off_idle: assert property (@(posedge clk) disable iff (rst)
        (ctrla_q[1:0] == 2'd0) && !conv_req |=> !conv_req);

    // R8: interrupt line needs global enable and a pending flag
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrla_q[CA_IE] && (pend_q != '0));

    // R9: a clear with no competing source leaves nothing pending
    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        bus_wr && (bus_addr == A_STAT) && !ext_trig && !hf_rise
        && !(conv_done && conv_req) |=> pend_q == '0);

    // R4: list never exceeds its capacity
    a_r4_list_cap: assert property (@(posedge clk) disable iff (rst)
        list_cnt <= ($clog2(LIST_DEPTH+1))'(LIST_DEPTH));

    // R5: sample FIFO never exceeds its capacity
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        sf_cnt <= ($clog2(SAMPLE_DEPTH+1))'(SAMPLE_DEPTH));
endmodule

bind adcq_ctrl adcq_checker #(
    .LIST_DEPTH   (LIST_DEPTH),
    .SAMPLE_DEPTH (SAMPLE_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .conv_cfg  (conv_cfg),
    .irq       (irq),
    .ctrla_q   (ctrla_q),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ext_trig  (ext_trig),
    .hf_rise   (hf_rise),
    .pend_q    (pend_q),
    .list_cnt  (list_cnt),
    .sf_cnt    (sf_cnt)
);

// File: tb/sim_adcq_ctrl.sv
`timescale 1ns/1ps
module sim_adcq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        conv_req;
    logic [7:0]  conv_cfg;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;
    logic        scan_tick = 1'b0, ext_trig = 1'b0;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adcq_ctrl u0 (.*);

    // vector table: list entries loaded in order, walked with wrap
    localparam logic [7:0] ENT [6] = '{8'h03, 8'h1F, 8'h25, 8'h4A, 8'h80, 8'hF6};

    function automatic logic [15:0] code_of(input logic [7:0] e);
        return {4'h0, e, 4'h5};
    endfunction

    // converter model: answers two cycles after a request
    initial begin
        forever begin
            @(negedge clk);
            if (conv_req) begin
                repeat (2) @(negedge clk);
                conv_code = {conv_cfg, 4'h5};
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (conv_req && g < 50) begin
            @(negedge clk);
            g++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_scan();
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk); scan_tick = 1'b0;
        wait_idle();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        br(5'h04, d);
        check("R5 reset status", d, 16'h0004);
        check("R8 reset irq", {15'b0, irq}, 16'h0000);
        check("R1 reset idle", {15'b0, conv_req}, 16'h0000);

        // enable list and sample FIFO, load the vector table, mode off
        bw(5'h02, 16'h0600);
        for (int i = 0; i < 6; i++) bw(5'h06, {8'h00, ENT[i]});
        br(5'h00, d);
        wait_idle();
        br(5'h04, d);
        check("R1 off mode start ignored", d, 16'h0004);

        // bus-read mode: walk the table twice to cover wrap
        bw(5'h00, 16'h0001);
        for (int i = 0; i < 12; i++) begin
            br(5'h00, d);
            check("R2 entry forwarded", {8'h00, conv_cfg}, {8'h00, ENT[i % 6]});
            wait_idle();
            br(5'h06, d);
            check("R3 R7 code in order", d, code_of(ENT[i % 6]));
        end
        br(5'h06, d);
        check("R7 empty read", d, 16'h0000);

        // R10: second start while busy is ignored
        br(5'h00, d);
        br(5'h00, d);
        wait_idle();
        br(5'h06, d);
        check("R10 one sample", d, code_of(ENT[0]));
        br(5'h04, d);
        check("R10 nothing more", d, 16'h0004);
        br(5'h00, d);
        wait_idle();
        br(5'h06, d);
        check("R10 head moved once", d, code_of(ENT[1]));

        // R6: list flush, writes while disabled dropped, empty list ignores start
        bw(5'h02, 16'h0400);
        bw(5'h06, 16'h0055);
        bw(5'h02, 16'h0600);
        br(5'h00, d);
        wait_idle();
        br(5'h04, d);
        check("R6 R10 flushed list no start", d, 16'h0004);

        // R4: fill list to capacity, extra write dropped
        bw(5'h06, 16'h0007);
        br(5'h04, d);
        check("R4 not full", d & 16'h0002, 16'h0000);
        for (int k = 1; k < 16; k++) bw(5'h06, 16'(8'h10 + k));
        br(5'h04, d);
        check("R4 full flag", d & 16'h0002, 16'h0002);
        bw(5'h06, 16'h00EE);
        for (int k = 0; k < 17; k++) begin
            logic [7:0] e;
            e = (k == 0 || k == 16) ? 8'h07 : 8'(8'h10 + k);
            br(5'h00, d);
            wait_idle();
            br(5'h06, d);
            check("R4 dropped write absent", d, code_of(e));
        end

        // R6: sample FIFO flush
        br(5'h00, d); wait_idle();
        br(5'h00, d); wait_idle();
        bw(5'h02, 16'h0200);
        bw(5'h02, 16'h0600);
        br(5'h04, d);
        check("R6 sample flush", d & 16'h001C, 16'h0004);

        // R5 R8 R11: scan mode fills sample FIFO
        bw(5'h02, 16'h0400);
        bw(5'h02, 16'h0600);
        bw(5'h06, 16'h002C);
        bw(5'h00, 16'h8102);
        br(5'h00, d); wait_idle();
        br(5'h04, d);
        check("R11 bus read ignored in scan mode", d & 16'h001C, 16'h0004);
        for (int k = 1; k <= 65; k++) begin
            pulse_scan();
            if (k == 31) begin
                br(5'h04, d);
                check("R5 below half", d & 16'h011C, 16'h0000);
            end
            if (k == 32) begin
                br(5'h04, d);
                check("R5 R8 half and pending", d & 16'h011C, 16'h0108);
                check("R8 irq high", {15'b0, irq}, 16'h0001);
            end
            if (k == 64) begin
                br(5'h04, d);
                check("R5 full", d & 16'h001C, 16'h0018);
            end
        end
        br(5'h04, d);
        check("R5 still full after extra", d & 16'h001C, 16'h0018);
        bw(5'h00, 16'h0102);
        check("R8 irq masked", {15'b0, irq}, 16'h0000);
        br(5'h04, d);
        check("R8 flag kept when masked", d & 16'h0100, 16'h0100);
        bw(5'h04, 16'h0000);
        br(5'h04, d);
        check("R9 cleared", d & 16'h0700, 16'h0000);
        begin
            int got = 0;
            for (int k = 0; k < 70; k++) begin
                br(5'h06, d);
                if (d == code_of(8'h2C)) got++;
            end
            check("R5 exactly 64 kept", 16'(got), 16'd64);
        end

        // R11 R8: external mode
        bw(5'h00, 16'h0203);
        pulse_scan();
        br(5'h04, d);
        check("R11 scan ignored in ext mode", d & 16'h001C, 16'h0004);
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        wait_idle();
        br(5'h06, d);
        check("R11 ext conversion", d, code_of(8'h2C));
        br(5'h04, d);
        check("R8 ext pending", d & 16'h0700, 16'h0200);
        check("R8 irq off without global enable", {15'b0, irq}, 16'h0000);

        // R9: clear and new external event on the same edge
        @(negedge clk);
        bus_addr = 5'h04; bus_wdata = 16'h0000; bus_wr = 1'b1; ext_trig = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ext_trig = 1'b0;
        wait_idle();
        br(5'h06, d);
        br(5'h04, d);
        check("R9 set wins over clear", d & 16'h0200, 16'h0200);
        bw(5'h04, 16'h0000);
        br(5'h04, d);
        check("R9 clear alone", d & 16'h0700, 16'h0000);

        // R8: list-wrap pending in bus mode with single entry
        bw(5'h00, 16'h8401);
        br(5'h00, d); wait_idle();
        br(5'h04, d);
        check("R8 list wrap pending", d & 16'h0400, 16'h0400);
        check("R8 irq from wrap", {15'b0, irq}, 16'h0001);

        summary();
    end
endmodule